// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block is a purely combinational binary adder built from 4-bit look-ahead units arranged in two levels. Each operand bit yields a generate term (both bits set) and a propagate term (the bits differ). The width is cut into 4-bit groups. Each group's look-ahead unit turns its four propagate/generate pairs and its incoming carry into the three carries inside the group. It also reports a group propagate and a group generate. A second look-ahead unit of the same shape takes four group pairs and the block carry-in. It produces the carry into each of the upper three groups at once, with no rippling between groups, and it reports the block-wide propagate and generate.

The whole-word propagate and generate are brought out, so a wider carry network can treat the adder as one cascadable block. A parameter selects a cascaded variant in which each group's carry-out feeds the next group in turn. That variant is slower in logic depth, but its sums must match the two-level form bit for bit. The width is a parameter that must be a multiple of 16. Each 16-bit slice owns its own second-level unit.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of a + b + cin, with all three read as unsigned numbers.
- R2: `cout` equals bit WIDTH of a + b + cin.
- R3: `grpP` is 1 exactly when every bit of a differs from the matching bit of b (a XOR b is all ones).
- R4: `grpG` is 1 exactly when a + b, with carry-in 0, carries out of bit WIDTH-1. `grpP` and `grpG` are never both 1.
- R5: `cout` equals grpG OR (grpP AND cin), so the block cascades through its exported pair.
- R6: A carry entering at bit 0 runs through any chain of ones. For all-ones plus 1 with cin 0, and for all-ones plus 0 with cin 1, `sum` is 0 and `cout` is 1.
- R7: With CARRY_MODE = 1 (group carries cascaded from one group to the next), `sum`, `cout`, `grpP` and `grpG` are identical to those of CARRY_MODE = 0 (two-level look-ahead) for every input.
- R8: The block holds no state. Every output is a function of the present a, b and cin only, and it is valid in the same cycle in which the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grpP | output | 1 | Whole-word propagate |
| grpG | output | 1 | Whole-word generate |

## Verification
No register lies between any input and any output, so every result is due in the cycle in which its operands are driven. The bench drives a, b and cin just after a rising edge. It reads the outputs of both carry variants at the following falling edge, half a period later, after the combinational logic has settled and well clear of the next edge. The expected sum, carry, propagate and generate are worked out in the bench with plain integer addition and XOR reduction on a word one bit wider than the adder.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_BITS = 4;
  localparam int unsigned BLK_BITS = 16;

  typedef struct packed {
    logic [GRP_BITS-1:0] prop;
    logic [GRP_BITS-1:0] gen;
  } nibblePg_t;
endpackage

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] p,
  input  logic [3:0] g,
  input  logic       cin,
  output logic [2:0] co,
  output logic       grpP,
  output logic       grpG
);
  always_comb begin
    co[0] = g[0] | (p[0] & cin);
    co[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    co[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin);
    grpP  = &p;
    grpG  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  end
endmodule

// File: rtl/cla_datapath.sv
module cla_datapath
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned NGRP = WIDTH / GRP_BITS
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] carries,
  output nibblePg_t        pgBus [NGRP],
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] propBits;
  logic [WIDTH-1:0] genBits;

  assign propBits = a ^ b;
  assign genBits  = a & b;
  assign sum      = propBits ^ carries;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_pack
    assign pgBus[gi].prop = propBits[GRP_BITS*gi +: GRP_BITS];
    assign pgBus[gi].gen  = genBits[GRP_BITS*gi +: GRP_BITS];
  end
endmodule

// File: rtl/cla_carry_ctrl.sv
module cla_carry_ctrl
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned CARRY_MODE = 0,
  localparam int unsigned NGRP = WIDTH / GRP_BITS,
  localparam int unsigned NBLK = WIDTH / BLK_BITS,
  localparam int unsigned GPB  = BLK_BITS / GRP_BITS
) (
  input  nibblePg_t        pgBus [NGRP],
  input  logic             cin,
  output logic [WIDTH-1:0] carries,
  output logic             cout,
  output logic             topP,
  output logic             topG
);
  logic [NGRP-1:0] grpP;
  logic [NGRP-1:0] grpG;
  logic [NGRP:0]   grpCin;
  logic [2:0]      grpCo [NGRP];
  logic [NBLK-1:0] blkP;
  logic [NBLK-1:0] blkG;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    cla_lookahead4 u_grp (
      .p    (pgBus[gi].prop),
      .g    (pgBus[gi].gen),
      .cin  (grpCin[gi]),
      .co   (grpCo[gi]),
      .grpP (grpP[gi]),
      .grpG (grpG[gi])
    );
    assign carries[GRP_BITS*gi]                = grpCin[gi];
    assign carries[GRP_BITS*gi+1 +: GRP_BITS-1] = grpCo[gi];
  end

  if (CARRY_MODE == 0) begin : g_twoLevel
    logic [NBLK:0] blkCin;
    logic [2:0]    lvl2Co [NBLK];
    assign blkCin[0] = cin;
    for (genvar bi = 0; bi < NBLK; bi++) begin : g_blk
      cla_lookahead4 u_lvl2 (
        .p    (grpP[GPB*bi +: GPB]),
        .g    (grpG[GPB*bi +: GPB]),
        .cin  (blkCin[bi]),
        .co   (lvl2Co[bi]),
        .grpP (blkP[bi]),
        .grpG (blkG[bi])
      );
      assign grpCin[GPB*bi]          = blkCin[bi];
      assign grpCin[GPB*bi+1 +: GPB-1] = lvl2Co[bi];
      assign blkCin[bi+1] = blkG[bi] | (blkP[bi] & blkCin[bi]);
    end
    assign grpCin[NGRP] = blkCin[NBLK];
  end else begin : g_cascade
    assign grpCin[0] = cin;
    for (genvar gi = 0; gi < NGRP; gi++) begin : g_chain
      assign grpCin[gi+1] = grpG[gi] | (grpP[gi] & grpCin[gi]);
    end
    for (genvar bi = 0; bi < NBLK; bi++) begin : g_blkPg
      assign blkP[bi] = &grpP[GPB*bi +: GPB];
      assign blkG[bi] = grpG[GPB*bi+3]
                      | (grpP[GPB*bi+3] & grpG[GPB*bi+2])
                      | (grpP[GPB*bi+3] & grpP[GPB*bi+2] & grpG[GPB*bi+1])
                      | (grpP[GPB*bi+3] & grpP[GPB*bi+2] & grpP[GPB*bi+1] & grpG[GPB*bi]);
    end
  end

  assign cout = grpCin[NGRP];

  always_comb begin
    topP = 1'b1;
    topG = 1'b0;
    for (int bi = 0; bi < NBLK; bi++) begin
      topG = blkG[bi] | (blkP[bi] & topG);
      topP = topP & blkP[bi];
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned CARRY_MODE = 0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             grpP,
  output logic             grpG
);
  localparam int unsigned NGRP = WIDTH / GRP_BITS;

  nibblePg_t        pgBus [NGRP];
  logic [WIDTH-1:0] carries;

  cla_datapath #(.WIDTH(WIDTH)) u_datapath (
    .a       (a),
    .b       (b),
    .carries (carries),
    .pgBus   (pgBus),
    .sum     (sum)
  );

  cla_carry_ctrl #(.WIDTH(WIDTH), .CARRY_MODE(CARRY_MODE)) u_ctrl (
    .pgBus   (pgBus),
    .cin     (cin),
    .carries (carries),
    .cout    (cout),
    .topP    (grpP),
    .topG    (grpG)
  );
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             grpP,
  input logic             grpG
);
  logic [WIDTH:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    // R1 and R2: sum and carry-out together equal the arithmetic total
    assert_sum_R1: assert ({cout, sum} == total)
      else $error("sum/cout mismatch");
    // R5: cascade relation on the exported pair
    assert_cascade_R5: assert (cout == (grpG | (grpP & cin)))
      else $error("cout does not follow grpP/grpG");
    // R3: propagate equals full-word difference
    assert_prop_R3: assert (grpP == (&(a ^ b)))
      else $error("grpP wrong");
    // R4: propagate and generate are exclusive
    assert_excl_R4: assert (!(grpP && grpG))
      else $error("grpP and grpG both set");
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout),
  .grpP (grpP),
  .grpG (grpG)
);

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum, sumR;
  logic         cout, coutR, pOut, pOutR, gOut, gOutR;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cla_adder #(.WIDTH(W), .CARRY_MODE(0)) u_cla_adder (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grpP(pOut), .grpG(gOut)
  );
  cla_adder #(.WIDTH(W), .CARRY_MODE(1)) u_cla_adder_ripple (
    .a(a), .b(b), .cin(cin), .sum(sumR), .cout(coutR), .grpP(pOutR), .grpG(gOutR)
  );

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic applyVec(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    logic [W:0] total;
    logic [W:0] noCin;
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
    total = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    noCin = {1'b0, va} + {1'b0, vb};
    // R8: outputs settle in the same cycle the operands are applied
    check("R1 sum", {1'b0, sum}, {1'b0, total[W-1:0]});
    check("R2 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, total[W]});
    check("R3 grpP", {{W{1'b0}}, pOut}, {{W{1'b0}}, &(va ^ vb)});
    check("R4 grpG", {{W{1'b0}}, gOut}, {{W{1'b0}}, noCin[W]});
    check("R5 cascade", {{W{1'b0}}, cout}, {{W{1'b0}}, gOut | (pOut & vc)});
    check("R7 variant", {pOutR, gOutR, coutR, sumR[W-3:0]}, {pOut, gOut, cout, sum[W-3:0]});
    check("R7 variantTop", {{(W-1){1'b0}}, sumR[W-1:W-2]}, {{(W-1){1'b0}}, sum[W-1:W-2]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rng;
    logic [W-1:0] hiPat [4];
    rng = 32'h1ACE_5EED;
    hiPat[0] = 16'h0000; hiPat[1] = 16'hFFFF; hiPat[2] = 16'hAAAA; hiPat[3] = 16'h5555;

    // reset-free combinational start: zero operands
    applyVec('0, '0, 1'b0);
    // R6: full-length carry run
    applyVec('1, 16'h0001, 1'b0);
    applyVec('1, '0, 1'b1);
    applyVec('1, '1, 1'b1);
    applyVec(16'hAAAA, 16'h5555, 1'b0);
    applyVec(16'hAAAA, 16'h5555, 1'b1);
    applyVec(16'h5555, 16'h5555, 1'b1);
    applyVec(16'h8000, 16'h8000, 1'b0);

    // R6: carry runs of every length, entered at bit 0
    for (int k = 0; k <= W; k++) begin
      logic [W:0] run;
      run = ({{W{1'b0}}, 1'b1} << k) - 1;
      applyVec(run[W-1:0], 16'h0001, 1'b0);
      applyVec(run[W-1:0], 16'h0000, 1'b1);
    end

    // near-exhaustive: each group position swept fully, others patterned
    for (int grp = 0; grp < 4; grp++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int x = 0; x < 16; x++) begin
          for (int y = 0; y < 16; y++) begin
            for (int c = 0; c < 2; c++) begin
              logic [W-1:0] va, vb;
              va = hiPat[pat];
              vb = ~hiPat[pat];
              va[4*grp +: 4] = 4'(x);
              vb[4*grp +: 4] = 4'(y);
              applyVec(va, vb, c[0]);
            end
          end
        end
      end
    end

    // pseudo-random operands
    for (int n = 0; n < 20000; n++) begin
      logic [W-1:0] va, vb;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      va = rng[W-1:0];
      vb = rng[31:32-W];
      applyVec(va, vb, rng[7]);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule